// File: doc/BRIEF.md
# Programmable Down-Counter with Vectored Interrupt

This block is a small byte-addressed timer peripheral. Software loads a 16-bit reload value as two bytes, selects what the counter steps on, and enables the timer event in a mask register. The counter then runs down from the reload value. A counting step taken while it already sits at zero reloads it and latches an event flag. The event flag, gated by its mask bit, pulls an active-low interrupt request.

When the processor acknowledges the interrupt, the block returns a programmable 8-bit vector on its read data. The service routine clears the request by reading a dedicated stop-command address. Each register access and each vector fetch is answered with a one-cycle data acknowledge on the following cycle. Read data is registered and is valid while the acknowledge is high.

Top module: `tick_timer_irq`

## Requirements
- R1: After reset, `irq_n` is 1, `ack` is 0, `rdata` is 0, and the control, mask, vector, status and both reload bytes read back as 0.
- R2: Register map on `addr`: 0 control, 1 mask, 2 status, 3 vector, 4 reload upper byte, 5 reload lower byte, 6 stop command. Control, mask, vector and both reload bytes read back the last value written. Unmapped addresses read 0.
- R3: `ack` is 1 for exactly the cycle after any write or read with `sel` high, or any cycle with `iack` high. In every other cycle it is 0.
- R4: Control bits [6:4] pick the counting source. 3'b111 (control value 0x70) steps once per cycle in which `ext_tick` is 1. 3'b110 (0x60) steps on every clock. Any other code holds the counter at the reload value and raises no event.
- R5: A step taken while the counter is 0 reloads it and sets the event flag. After the counting mode is entered, the first event comes on step reload+1, and later events follow every reload+1 steps.
- R6: Status reads return the event flag in bit 3 with all other bits 0. Writes to the status address have no effect.
- R7: `irq_n` is 0 exactly when the event flag and mask bit 3 are both 1. The other mask bits have no effect on `irq_n`.
- R8: A read of the stop-command address returns 0 and clears the event flag. If an event occurs in the same cycle, the flag stays set.
- R9: While `iack` is 1, the next cycle's `rdata` holds the vector register, whatever `sel` is.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe (with sel) |
| rd | input | 1 | Read strobe (with sel) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| iack | input | 1 | Interrupt acknowledge; requests the vector |
| ext_tick | input | 1 | Synchronous one-cycle counting enable from an external source |
| rdata | output | 8 | Registered read data, valid while ack is 1 |
| ack | output | 1 | Data acknowledge, one cycle after an access |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `ext_tick` is already synchronous to `clk`. They also assume that `iack` and a register access are never raised in the same cycle, and that every access lasts a single cycle. The bench drives every strobe and tick at the falling edge and keeps each one high for exactly one cycle. It never overlaps an acknowledge with a register access. The reload sweep uses small values so that event timing can be counted edge by edge from the moment the mode is written.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register addresses
  localparam int RA_CTRL   = 0;
  localparam int RA_MASK   = 1;
  localparam int RA_STAT   = 2;
  localparam int RA_VEC    = 3;
  localparam int RA_PRE_HI = 4;
  localparam int RA_PRE_LO = 5;
  localparam int RA_STOP   = 6;

  // counting-source field inside the control register
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam logic [MODE_W-1:0] MODE_EXT = 3'b111;
  localparam logic [MODE_W-1:0] MODE_CLK = 3'b110;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int EVT_BIT = 3,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       iack,
  input  logic                       flag,
  output logic [DATA_W-1:0]          rdata,
  output logic                       ack,
  output logic [tmr_pkg::MODE_W-1:0] mode,
  output logic                       mask_evt,
  output logic [CNT_W-1:0]           preload,
  output logic                       stop_rd
);
  import tmr_pkg::*;

  logic [DATA_W-1:0] ctrl_q, mask_q, vec_q, pre_hi_q, pre_lo_q;
  logic [DATA_W-1:0] rd_mux, stat_val;
  logic wr_en, rd_en, access;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ra);
    return a == ADDR_W'(ra);
  endfunction

  assign access  = iack | (sel & (rd | wr));
  assign wr_en   = sel & wr & ~iack;
  assign rd_en   = sel & rd & ~wr & ~iack;
  assign stop_rd = rd_en & hit(addr, RA_STOP);

  always_comb begin
    stat_val = '0;
    stat_val[EVT_BIT] = flag;
  end

  always_comb begin
    rd_mux = '0;
    if (hit(addr, RA_CTRL))   rd_mux = ctrl_q;
    if (hit(addr, RA_MASK))   rd_mux = mask_q;
    if (hit(addr, RA_STAT))   rd_mux = stat_val;
    if (hit(addr, RA_VEC))    rd_mux = vec_q;
    if (hit(addr, RA_PRE_HI)) rd_mux = pre_hi_q;
    if (hit(addr, RA_PRE_LO)) rd_mux = pre_lo_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; mask_q <= '0; vec_q <= '0;
      pre_hi_q <= '0; pre_lo_q <= '0;
      rdata <= '0; ack <= 1'b0;
    end else begin
      ack <= access;
      if (wr_en) begin
        if (hit(addr, RA_CTRL))   ctrl_q   <= wdata;
        if (hit(addr, RA_MASK))   mask_q   <= wdata;
        if (hit(addr, RA_VEC))    vec_q    <= wdata;
        if (hit(addr, RA_PRE_HI)) pre_hi_q <= wdata;
        if (hit(addr, RA_PRE_LO)) pre_lo_q <= wdata;
      end
      if (iack)       rdata <= vec_q;
      else if (rd_en) rdata <= rd_mux;
    end
  end

  assign mode     = ctrl_q[MODE_LSB +: MODE_W];
  assign mask_evt = mask_q[EVT_BIT];
  assign preload  = {pre_hi_q, pre_lo_q};

  AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> ack); // R3
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !ack); // R3
  AST_VECTOR_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> rdata == $past(vec_q)); // R9
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [tmr_pkg::MODE_W-1:0] mode,
  input  logic                       ext_tick,
  input  logic [CNT_W-1:0]           preload,
  output logic                       underflow
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic running, step;

  function automatic logic [CNT_W-1:0] next_cnt(
      input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p,
      input logic on, input logic st);
    if (!on)       return p;
    if (!st)       return c;
    if (c == '0)   return p;
    return c - CNT_W'(1);
  endfunction

  assign running   = (mode == MODE_EXT) || (mode == MODE_CLK);
  assign step      = (mode == MODE_CLK) || ((mode == MODE_EXT) && ext_tick);
  assign underflow = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, preload, running, step);
  end

  AST_RELOAD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> cnt_q == $past(preload)); // R5
  AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !step) |=> $stable(cnt_q)); // R4
  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !underflow); // R4
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic stop_rd,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (underflow) flag <= 1'b1;
    else if (stop_rd)   flag <= 1'b0;
  end

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> flag); // R5
  AST_STOP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_rd && !underflow) |=> !flag); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_rd && !underflow) |=> flag == $past(flag)); // R6
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int EVT_BIT = 3,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iack,
  input  logic              ext_tick,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic              irq_n
);
  logic [tmr_pkg::MODE_W-1:0] mode;
  logic [CNT_W-1:0]           preload;
  logic mask_evt, stop_rd, underflow, flag;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_BIT(EVT_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .iack(iack), .flag(flag), .rdata(rdata), .ack(ack),
    .mode(mode), .mask_evt(mask_evt), .preload(preload), .stop_rd(stop_rd));

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_tick(ext_tick),
    .preload(preload), .underflow(underflow));

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .underflow(underflow), .stop_rd(stop_rd),
    .flag(flag));

  assign irq_n = ~(flag & mask_evt);

  AST_REQUEST_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && mask_evt && !wr) |=> !irq_n); // R7
endmodule

// File: tb/tb_tick_timer_irq.sv
module tb_tick_timer_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr = 0, rd = 0, iack = 0, ext_tick = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ack, irq_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_timer_irq dut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .iack(iack), .ext_tick(ext_tick),
    .rdata(rdata), .ack(ack), .irq_n(irq_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    sel = 1; wr = w; rd = ~w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 0; wr = 0; rd = 0;
    q = rdata;
    chk("R3 ack after access", ack, 1);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] q);
    bus(1'b0, a, 8'h00, q);
  endtask

  task automatic tick();
    @(negedge clk); ext_tick = 1;
    @(negedge clk); ext_tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 ack", ack, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1;
    for (int a = 0; a < 6; a++) begin
      rreg(4'(a), q); chk("R1 reg reset value", q, 0);
    end
    // R2 readback
    wreg(0, 8'h05); wreg(1, 8'hA5); wreg(3, 8'h40); wreg(4, 8'h12); wreg(5, 8'h34);
    rreg(0, q); chk("R2 ctrl", q, 8'h05);
    rreg(1, q); chk("R2 mask", q, 8'hA5);
    rreg(3, q); chk("R2 vector", q, 8'h40);
    rreg(4, q); chk("R2 reload hi", q, 8'h12);
    rreg(5, q); chk("R2 reload lo", q, 8'h34);
    rreg(9, q); chk("R2 unmapped", q, 0);
    // R6 status write ignored
    wreg(2, 8'hFF); rreg(2, q); chk("R6 status write ignored", q, 0);
    // R3 idle gives no ack
    @(negedge clk); chk("R3 idle no ack", ack, 0);
    // R9 vector on acknowledge, sel low
    iack = 1; @(negedge clk); iack = 0;
    chk("R9 vector", rdata, 8'h40); chk("R3 ack on iack", ack, 1);
    @(negedge clk); chk("R3 single ack", ack, 0);

    // R5 sweep reload values in every-clock mode
    wreg(1, 8'h08);
    for (int p = 0; p < 6; p++) begin
      wreg(0, 8'h00); rreg(6, q);
      chk("R8 stop read returns 0", q, 0);
      chk("R8 cleared", irq_n, 1);
      wreg(4, 8'h00); wreg(5, 8'(p));
      wreg(0, 8'h60);
      for (int k = 1; k <= p; k++) begin
        @(negedge clk); chk("R5 no early event", irq_n, 1);
      end
      @(negedge clk); chk("R5 event at reload+1", irq_n, 0);
      wreg(0, 8'h00);
      rreg(2, q); chk("R6 status bit3", q, 8'h08);
    end

    // R4 external ticks, value 0x70
    wreg(5, 8'h02); rreg(6, q); wreg(0, 8'h70);
    tick(); repeat (3) @(negedge clk); tick();
    chk("R4 two ticks no event", irq_n, 1);
    repeat (4) @(negedge clk);
    chk("R4 no step without tick", irq_n, 1);
    tick(); chk("R4 event on third tick", irq_n, 0);
    rreg(6, q); chk("R8 clear in ext mode", irq_n, 1);
    tick(); tick(); chk("R5 reloaded period", irq_n, 1);
    tick(); chk("R5 second event", irq_n, 0);

    // R4 other codes hold the counter
    wreg(0, 8'h00); rreg(6, q);
    for (int i = 0; i < 8; i++) tick();
    chk("R4 off mode no event", irq_n, 1);
    wreg(0, 8'h50);
    for (int i = 0; i < 8; i++) tick();
    chk("R4 code 101 no event", irq_n, 1);
    repeat (8) @(negedge clk);
    chk("R4 code 101 no clock stepping", irq_n, 1);

    // R7 mask bits: set flag, stop counting
    wreg(5, 8'h00); wreg(0, 8'h60); wreg(0, 8'h00);
    for (int b = 0; b < 8; b++) begin
      wreg(1, 8'(1 << b));
      chk("R7 single mask bit", irq_n, (b == 3) ? 1'b0 : 1'b1);
    end
    wreg(1, 8'hF7); chk("R7 other bits no effect", irq_n, 1);
    wreg(1, 8'h08); chk("R7 flag and mask", irq_n, 0);

    // R8 event in same cycle as stop read
    wreg(0, 8'h60);
    rreg(6, q); chk("R8 event wins over clear", irq_n, 0);
    rreg(2, q); chk("R8 status still set", q, 8'h08);
    wreg(0, 8'h00); rreg(6, q); chk("R8 clear when idle", irq_n, 1);

    finish_run();
  end
endmodule